// File: doc/BRIEF.md
# Byte-Enable Local Bus Access Controller

This block carries one 32-bit host target access at a time onto a 16-bit local bus. The host side gives a request with a write flag, a half-word address, four active-low byte enables and write data. The block turns the byte-enable pattern into the two low local address bits, an active-low high-byte enable and a choice of data half. It then runs one local read or write strobe and returns a one-cycle response with a status code and, for reads, the data.

Patterns that the 16-bit bus cannot serve are refused with an abort, and no local cycle is started. An access with no bytes enabled completes at once, with no local cycle. The strobe length comes from one of two sources. In wait-count mode it is a configured number of cycles. In ready mode it lasts until the external ready input is seen. If ready does not arrive in time, the access ends with a retry response and sets a sticky error flag, which software clears with a write-one-to-clear strobe. The host clock and the local clock are the same clock. The requester issues a new request only after the response to the previous one.

Top module: `bec_lbus_ctrl`

## Requirements
- R1: After reset, rsp_valid, lb_cyc, lb_oe and err_flag are 0, and lb_rd_n, lb_wr_n and lb_bhe_n are 1.
- R2: Single-byte patterns (bit 0 is byte 0, a bit value of 0 means enabled) decode to local address bits {A1,A0} and lb_bhe_n as follows: 1110 gives 00 with lb_bhe_n=1, 1101 gives 01 with 0, 1011 gives 10 with 1, 0111 gives 11 with 0. lb_addr is {req_addr, A1, A0}.
- R3: Pattern 1100 gives a 16-bit access at A1=0 and pattern 0011 gives one at A1=1. Both have A0=0 and lb_bhe_n=0.
- R4: On a write, lb_dout carries req_wdata[15:0] when A1=0 and req_wdata[31:16] when A1=1, lb_oe is 1, and only lb_wr_n is low while lb_cyc is 1.
- R5: On a completed read, lb_din[7:0] goes to host byte 2·A1 and lb_din[15:8] goes to byte 2·A1+1, kept only for the enabled bytes. All other bytes read as zero.
- R6: Every other pattern with at least one enable asserted, and every non-empty pattern while cfg_bus8 is 1, gives an abort response (rsp_code 1) one cycle after the request, with no local cycle.
- R7: Pattern 1111 gives an OK response (rsp_code 0) with zero data one cycle after the request, with no local cycle.
- R8: In wait-count mode (cfg_use_rdy=0), with cfg_wait N in 1..11, lb_cyc and the strobe stay active for exactly N cycles. The OK response appears in the cycle right after the strobe ends.
- R9: cfg_wait values 0 and 12 to 15 produce an 11-cycle strobe.
- R10: In ready mode, the access completes OK in the cycle after the first edge at which lb_rdy is sampled high, if that happens within the first 9 strobe cycles. The strobe lasts that many cycles.
- R11: In ready mode, if lb_rdy is not sampled high within 9 strobe cycles, the strobe ends after the 9th cycle, the response is a retry (rsp_code 2) with zero data, and err_flag becomes 1.
- R12: err_flag stays at 1 until an err_clr pulse. If a timeout and err_clr fall on the same edge, the flag stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared host and local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | LA_W-2 | Local half-word address bits above A1 |
| req_be_n | input | 4 | Active-low host byte enables |
| req_wdata | input | 32 | Host write data |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_code | output | 2 | 0 OK, 1 abort, 2 retry |
| rsp_rdata | output | 32 | Read data placed in host byte lanes |
| cfg_bus8 | input | 1 | Bus-width select; 0 selects 16-bit operation |
| cfg_use_rdy | input | 1 | 1 ends strobes on lb_rdy, 0 uses cfg_wait |
| cfg_wait | input | WAIT_W | Programmed strobe length |
| err_clr | input | 1 | Write-one-to-clear pulse for err_flag |
| err_flag | output | 1 | Sticky timeout error |
| lb_cyc | output | 1 | Local cycle in progress; address valid |
| lb_addr | output | LA_W | Local address |
| lb_bhe_n | output | 1 | Active-low high-byte enable |
| lb_rd_n | output | 1 | Active-low read strobe |
| lb_wr_n | output | 1 | Active-low write strobe |
| lb_oe | output | 1 | Data output enable for lb_dout |
| lb_dout | output | 16 | Local write data |
| lb_din | input | 16 | Local read data |
| lb_rdy | input | 1 | External ready |

## Verification
The timeout that sets the error flag and the software clear strobe can land on the same clock edge. The bench provokes this by raising err_clr exactly on the 9th strobe cycle of a ready-mode access that never sees ready. It then requires the flag to read 1, followed by a clean clear on a later pulse. A second same-edge case is ready arriving on the very last allowed cycle. There the completion must win over the timeout, which the bench judges by an OK response, a 9-cycle strobe and an error flag that stays clear.

// File: rtl/bec_pkg.sv
package bec_pkg;

   typedef enum logic [1:0] {
      RSP_OK    = 2'd0,
      RSP_ABORT = 2'd1,
      RSP_RETRY = 2'd2
   } rsp_code_e;

   typedef struct packed {
      logic       legal;
      logic       a1;
      logic       a0;
      logic       bhe_n;
      logic [3:0] bmask;
   } lane_sel_t;

   // Put a 16-bit local word in the selected host half and zero the
   // bytes that were not enabled.
   function automatic logic [31:0] place_lanes(input logic [15:0] din,
                                               input logic        a1,
                                               input logic [3:0]  bmask);
      logic [31:0] w;
      w = a1 ? {din, 16'h0000} : {16'h0000, din};
      for (int i = 0; i < 4; i++) begin
         if (!bmask[i]) w[i*8 +: 8] = 8'h00;
      end
      return w;
   endfunction

endpackage

// File: rtl/bec_lane_decode.sv
module bec_lane_decode
   import bec_pkg::*;
(
   input  logic [3:0] be_n,
   output lane_sel_t  sel
);

   always_comb begin
      sel       = '0;
      sel.bhe_n = 1'b1;
      sel.bmask = ~be_n;
      case (be_n)
         4'b1110: begin sel.legal = 1'b1;                                   end
         4'b1101: begin sel.legal = 1'b1; sel.a0 = 1'b1; sel.bhe_n = 1'b0;  end
         4'b1011: begin sel.legal = 1'b1; sel.a1 = 1'b1;                    end
         4'b0111: begin sel.legal = 1'b1; sel.a1 = 1'b1; sel.a0 = 1'b1;
                        sel.bhe_n = 1'b0;                                   end
         4'b1100: begin sel.legal = 1'b1; sel.bhe_n = 1'b0;                 end
         4'b0011: begin sel.legal = 1'b1; sel.a1 = 1'b1; sel.bhe_n = 1'b0;  end
         default: begin sel.legal = 1'b0;                                   end
      endcase
   end

endmodule

// File: rtl/bec_xfer_timer.sv
module bec_xfer_timer #(
   parameter int WAIT_W    = 4,
   parameter int WAIT_MAX  = 11,
   parameter int RDY_LIMIT = 9,
   parameter bit SYNC_RDY  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              use_rdy,
   input  logic [WAIT_W-1:0] wait_cfg,
   input  logic              rdy_in,
   output logic              done,
   output logic              tmo
);

   localparam int CNT_TOP = (WAIT_MAX > RDY_LIMIT) ? WAIT_MAX : RDY_LIMIT;
   localparam int CNT_W   = $clog2(CNT_TOP + 1);
   localparam logic [WAIT_W-1:0] WMAX = WAIT_W'(WAIT_MAX);
   localparam logic [CNT_W-1:0]  RLIM = CNT_W'(RDY_LIMIT);

   if (WAIT_MAX < 1 || WAIT_MAX >= (1 << WAIT_W)) begin : g_bad_wait
      $error("WAIT_MAX must fit in WAIT_W bits and be at least 1");
   end
   if (RDY_LIMIT < 1) begin : g_bad_limit
      $error("RDY_LIMIT must be at least 1");
   end

   logic rdy_s;
   if (SYNC_RDY) begin : g_sync
      logic [1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[0], rdy_in};
      end
      assign rdy_s = sync_q[1];
   end else begin : g_direct
      assign rdy_s = rdy_in;
   end

   logic              act_q, mode_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [WAIT_W-1:0] lim_q, eff_wait;

   always_comb begin
      if (wait_cfg == '0 || wait_cfg > WMAX) eff_wait = WMAX;
      else                                   eff_wait = wait_cfg;
   end

   assign done = act_q & (mode_q ? rdy_s : (cnt_q == CNT_W'(lim_q)));
   assign tmo  = act_q & mode_q & ~rdy_s & (cnt_q == RLIM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         mode_q <= 1'b0;
         cnt_q  <= '0;
         lim_q  <= '0;
      end else if (start) begin
         act_q  <= 1'b1;
         mode_q <= use_rdy;
         cnt_q  <= CNT_W'(1);
         lim_q  <= eff_wait;
      end else if (act_q) begin
         if (done || tmo) act_q <= 1'b0;
         else             cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   a_r10_rdy_window: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && mode_q) |-> (cnt_q <= RLIM));
   a_r8_wait_window: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !mode_q) |-> (cnt_q <= CNT_W'(lim_q)));
   a_r9_limit_range: assert property (@(posedge clk) disable iff (!rst_n)
      act_q |-> (lim_q != '0 && lim_q <= WMAX));
   a_r11_tmo_ends: assert property (@(posedge clk) disable iff (!rst_n)
      tmo |=> !act_q);

endmodule

// File: rtl/bec_err_reg.sv
module bec_err_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag);
   a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !flag);

endmodule

// File: rtl/bec_lbus_ctrl.sv
module bec_lbus_ctrl
   import bec_pkg::*;
#(
   parameter int LA_W      = 16,
   parameter int WAIT_W    = 4,
   parameter int WAIT_MAX  = 11,
   parameter int RDY_LIMIT = 9,
   parameter bit SYNC_RDY  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [LA_W-3:0]   req_addr,
   input  logic [3:0]        req_be_n,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic [1:0]        rsp_code,
   output logic [31:0]       rsp_rdata,
   input  logic              cfg_bus8,
   input  logic              cfg_use_rdy,
   input  logic [WAIT_W-1:0] cfg_wait,
   input  logic              err_clr,
   output logic              err_flag,
   output logic              lb_cyc,
   output logic [LA_W-1:0]   lb_addr,
   output logic              lb_bhe_n,
   output logic              lb_rd_n,
   output logic              lb_wr_n,
   output logic              lb_oe,
   output logic [15:0]       lb_dout,
   input  logic [15:0]       lb_din,
   input  logic              lb_rdy
);

   if (LA_W < 3) begin : g_bad_la
      $error("LA_W must be at least 3");
   end

   lane_sel_t dec;
   logic accept, is_nop, go, refuse;
   logic t_done, t_tmo, fin;
   logic wr_q, a1_q;
   logic [3:0] mask_q;

   bec_lane_decode u_dec (.be_n(req_be_n), .sel(dec));

   assign accept = req_valid & ~lb_cyc;
   assign is_nop = (req_be_n == 4'b1111);
   assign go     = accept & ~is_nop & dec.legal & ~cfg_bus8;
   assign refuse = accept & ~is_nop & (~dec.legal | cfg_bus8);
   assign fin    = lb_cyc & (t_done | t_tmo);

   bec_xfer_timer #(
      .WAIT_W(WAIT_W), .WAIT_MAX(WAIT_MAX),
      .RDY_LIMIT(RDY_LIMIT), .SYNC_RDY(SYNC_RDY)
   ) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(go), .use_rdy(cfg_use_rdy),
      .wait_cfg(cfg_wait), .rdy_in(lb_rdy), .done(t_done), .tmo(t_tmo)
   );

   bec_err_reg u_err (
      .clk(clk), .rst_n(rst_n), .set(lb_cyc & t_tmo & ~t_done),
      .clr(err_clr), .flag(err_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lb_cyc    <= 1'b0;
         lb_addr   <= '0;
         lb_bhe_n  <= 1'b1;
         lb_rd_n   <= 1'b1;
         lb_wr_n   <= 1'b1;
         lb_oe     <= 1'b0;
         lb_dout   <= '0;
         wr_q      <= 1'b0;
         a1_q      <= 1'b0;
         mask_q    <= '0;
         rsp_valid <= 1'b0;
         rsp_code  <= RSP_OK;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= 1'b0;
         if (go) begin
            lb_cyc   <= 1'b1;
            lb_addr  <= {req_addr, dec.a1, dec.a0};
            lb_bhe_n <= dec.bhe_n;
            lb_rd_n  <= req_write;
            lb_wr_n  <= ~req_write;
            lb_oe    <= req_write;
            lb_dout  <= dec.a1 ? req_wdata[31:16] : req_wdata[15:0];
            wr_q     <= req_write;
            a1_q     <= dec.a1;
            mask_q   <= dec.bmask;
         end else if (accept) begin
            rsp_valid <= 1'b1;
            rsp_code  <= refuse ? RSP_ABORT : RSP_OK;
            rsp_rdata <= '0;
         end
         if (fin) begin
            lb_cyc    <= 1'b0;
            lb_addr   <= '0;
            lb_bhe_n  <= 1'b1;
            lb_rd_n   <= 1'b1;
            lb_wr_n   <= 1'b1;
            lb_oe     <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_code  <= t_done ? RSP_OK : RSP_RETRY;
            rsp_rdata <= (t_done && !wr_q) ? place_lanes(lb_din, a1_q, mask_q) : '0;
         end
      end
   end

   a_r6_abort_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      refuse |=> (rsp_valid && rsp_code == RSP_ABORT && !lb_cyc));
   a_r7_empty_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && is_nop) |=> (rsp_valid && rsp_code == RSP_OK && rsp_rdata == '0 && !lb_cyc));
   a_r11_retry_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code == RSP_RETRY) |-> err_flag);
   a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      lb_cyc |-> (lb_rd_n != lb_wr_n));
   a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
      !lb_cyc |-> (lb_rd_n && lb_wr_n && lb_bhe_n && !lb_oe));
   a_r3_wide_bhe: assert property (@(posedge clk) disable iff (!rst_n)
      (lb_cyc && lb_addr[0]) |-> !lb_bhe_n);

endmodule

// File: tb/sim_bec_lbus_ctrl.sv
module sim_bec_lbus_ctrl;

   localparam int LA_W = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [13:0] req_addr = '0;
   logic [3:0]  req_be_n = 4'hF;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [1:0]  rsp_code;
   logic [31:0] rsp_rdata;
   logic        cfg_bus8 = 1'b0, cfg_use_rdy = 1'b0;
   logic [3:0]  cfg_wait = 4'd3;
   logic        err_clr = 1'b0, err_flag;
   logic        lb_cyc, lb_bhe_n, lb_rd_n, lb_wr_n, lb_oe;
   logic [15:0] lb_addr, lb_dout;
   logic [15:0] lb_din = 16'hB74E;
   logic        lb_rdy = 1'b0;

   int n_chk = 0, n_fail = 0;

   typedef struct {
      logic [1:0]  code;
      logic [31:0] rd;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #2 clk = ~clk;

   bec_lbus_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_be_n(req_be_n), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
      .cfg_bus8(cfg_bus8), .cfg_use_rdy(cfg_use_rdy), .cfg_wait(cfg_wait),
      .err_clr(err_clr), .err_flag(err_flag), .lb_cyc(lb_cyc), .lb_addr(lb_addr),
      .lb_bhe_n(lb_bhe_n), .lb_rd_n(lb_rd_n), .lb_wr_n(lb_wr_n), .lb_oe(lb_oe),
      .lb_dout(lb_dout), .lb_din(lb_din), .lb_rdy(lb_rdy)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   // {legal, A1, A0, bhe_n} per the decode table of R2/R3
   function automatic logic [3:0] lane_of(input logic [3:0] be);
      case (be)
         4'b1110: return 4'b1001;
         4'b1101: return 4'b1010;
         4'b1011: return 4'b1101;
         4'b0111: return 4'b1110;
         4'b1100: return 4'b1000;
         4'b0011: return 4'b1100;
         default: return 4'b0000;
      endcase
   endfunction

   // expected read word per R5
   function automatic logic [31:0] rd_of(input logic [3:0] be, input logic [15:0] d);
      logic [31:0] w;
      w = lane_of(be)[2] ? {d, 16'h0} : {16'h0, d};
      for (int i = 0; i < 4; i++) if (be[i]) w[i*8 +: 8] = 8'h00;
      return w;
   endfunction

   // monitor: pop expected responses as they appear
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sb.size() == 0) chk("R7 unexpected response", 32'h1, 32'h0);
         else begin
            exp_t e;
            e = sb.pop_front();
            chk({e.tag, " code"}, {30'h0, rsp_code}, {30'h0, e.code});
            chk({e.tag, " data"}, rsp_rdata, e.rd);
         end
      end
   end

   task automatic access(input logic [3:0] be, input logic wr, input logic [13:0] adr,
                         input logic [31:0] wd, input int rdy_at, input int clr_at,
                         input int exp_len, input logic [1:0] code, input logic [31:0] rd,
                         input string tag);
      exp_t e;
      logic [3:0] l;
      int k;
      e.code = code; e.rd = rd; e.tag = tag;
      sb.push_back(e);
      l = lane_of(be);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = adr; req_be_n = be; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      k = 0;
      while (lb_cyc && k < 40) begin
         k++;
         if (k == 1) begin
            chk({tag, " R2 addr"}, {16'h0, lb_addr}, {16'h0, adr, l[2], l[1]});
            chk({tag, " R3 bhe_n"}, {31'h0, lb_bhe_n}, {31'h0, l[0]});
            chk({tag, " R4 strobes"}, {29'h0, lb_rd_n, lb_wr_n, lb_oe}, {29'h0, wr, !wr, wr});
            if (wr) chk({tag, " R4 dout"}, {16'h0, lb_dout}, {16'h0, l[2] ? wd[31:16] : wd[15:0]});
         end
         lb_rdy  = (k == rdy_at);
         err_clr = (k == clr_at);
         @(negedge clk);
      end
      lb_rdy = 1'b0; err_clr = 1'b0;
      chk({tag, " strobe length"}, k, exp_len);
      repeat (2) @(negedge clk);
   endtask

   task automatic pulse_clr();
      @(negedge clk); err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      chk("watchdog expired", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 reset outputs", {26'h0, rsp_valid, lb_cyc, lb_oe, err_flag, lb_rd_n, lb_wr_n},
          {26'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1});
      chk("R1 reset bhe_n", {31'h0, lb_bhe_n}, 32'h1);

      // R2/R3/R4/R8 writes on every legal pattern, wait count 3
      foreach (lane_of_list[i]) begin
         access(lane_of_list[i], 1'b1, 14'h1A5 + 14'(i), 32'hC0DE_F00D, 0, 0, 3, 2'd0, 32'h0,
                $sformatf("R8 write be=%b", lane_of_list[i]));
      end
      // R5 reads on every legal pattern
      foreach (lane_of_list[i]) begin
         lb_din = 16'hB74E ^ 16'(i * 16'h1111);
         access(lane_of_list[i], 1'b0, 14'h0042, 32'h0, 0, 0, 3, 2'd0,
                rd_of(lane_of_list[i], lb_din), $sformatf("R5 read be=%b", lane_of_list[i]));
      end
      // R6 unsupported patterns
      access(4'b1010, 1'b1, 14'h3, 32'h1, 0, 0, 0, 2'd1, 32'h0, "R6 abort 1010");
      access(4'b0000, 1'b0, 14'h3, 32'h1, 0, 0, 0, 2'd1, 32'h0, "R6 abort 0000");
      access(4'b1001, 1'b0, 14'h3, 32'h1, 0, 0, 0, 2'd1, 32'h0, "R6 abort 1001");
      access(4'b0110, 1'b1, 14'h3, 32'h1, 0, 0, 0, 2'd1, 32'h0, "R6 abort 0110");
      cfg_bus8 = 1'b1;
      access(4'b1100, 1'b1, 14'h3, 32'h1, 0, 0, 0, 2'd1, 32'h0, "R6 abort width bit set");
      access(4'b1111, 1'b0, 14'h3, 32'h1, 0, 0, 0, 2'd0, 32'h0, "R7 empty with width bit set");
      cfg_bus8 = 1'b0;
      // R7 empty pattern
      access(4'b1111, 1'b0, 14'h7, 32'h1, 0, 0, 0, 2'd0, 32'h0, "R7 empty read");
      access(4'b1111, 1'b1, 14'h7, 32'h1, 0, 0, 0, 2'd0, 32'h0, "R7 empty write");
      // R8/R9 programmed lengths
      cfg_wait = 4'd1;  access(4'b1110, 1'b1, 14'h9, 32'h5, 0, 0, 1, 2'd0, 32'h0, "R8 wait 1");
      cfg_wait = 4'd11; access(4'b1110, 1'b1, 14'h9, 32'h5, 0, 0, 11, 2'd0, 32'h0, "R8 wait 11");
      cfg_wait = 4'd0;  access(4'b1110, 1'b1, 14'h9, 32'h5, 0, 0, 11, 2'd0, 32'h0, "R9 wait 0");
      cfg_wait = 4'd12; access(4'b1110, 1'b1, 14'h9, 32'h5, 0, 0, 11, 2'd0, 32'h0, "R9 wait 12");
      cfg_wait = 4'd15; access(4'b1110, 1'b1, 14'h9, 32'h5, 0, 0, 11, 2'd0, 32'h0, "R9 wait 15");
      // R10 ready mode
      cfg_use_rdy = 1'b1; cfg_wait = 4'd2;
      lb_din = 16'h9A3C;
      access(4'b1100, 1'b0, 14'h11, 32'h0, 1, 0, 1, 2'd0, rd_of(4'b1100, 16'h9A3C), "R10 ready at 1");
      access(4'b0011, 1'b0, 14'h11, 32'h0, 5, 0, 5, 2'd0, rd_of(4'b0011, 16'h9A3C), "R10 ready at 5");
      access(4'b0111, 1'b0, 14'h11, 32'h0, 9, 0, 9, 2'd0, rd_of(4'b0111, 16'h9A3C), "R10 ready at 9");
      chk("R10 last-cycle ready leaves error clear", {31'h0, err_flag}, 32'h0);
      // R11 timeout
      access(4'b1100, 1'b0, 14'h22, 32'h0, 0, 0, 9, 2'd2, 32'h0, "R11 timeout");
      chk("R11 error set", {31'h0, err_flag}, 32'h1);
      // R12 sticky across a good access
      access(4'b1110, 1'b1, 14'h22, 32'h7, 2, 0, 2, 2'd0, 32'h0, "R12 good access");
      chk("R12 sticky", {31'h0, err_flag}, 32'h1);
      pulse_clr();
      @(negedge clk);
      chk("R12 cleared", {31'h0, err_flag}, 32'h0);
      // R12 clear on the same edge as the timeout
      access(4'b0011, 1'b1, 14'h33, 32'h8, 0, 9, 9, 2'd2, 32'h0, "R12 collide");
      chk("R12 set wins over clear", {31'h0, err_flag}, 32'h1);
      pulse_clr();
      @(negedge clk);
      chk("R12 cleared after collision", {31'h0, err_flag}, 32'h0);

      repeat (3) @(negedge clk);
      chk("R7 all responses seen", sb.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   logic [3:0] lane_of_list [6] = '{4'b1110, 4'b1101, 4'b1011, 4'b0111, 4'b1100, 4'b0011};

endmodule